// File: doc/BRIEF.md
# Control Register Move Unit

This block holds the six privileged control registers that a processor core reaches through its move-to-control and move-from-control instructions. It also decides whether each such access is allowed. A request presents a 12-bit register number, a direction flag, 32 bits of write data and a flag that marks a base-level core. One clock later the unit answers with either:

- a completed access, which for a read carries the register contents, or
- an illegal-instruction indication together with the 16-bit opcode that the core should trap with.

The registers are:

- the source and destination function codes,
- the user stack pointer,
- the vector base,
- two 8-bit cache registers, one for control and one for an address.

Register numbers are sparse, so most of the 12-bit space is undefined. A base-level core also refuses any number whose low 11 bits are above 1.

Top module: `ctlreg_move_unit`

## Requirements
- R1: Register number 0x000 selects the source function code, 0x001 the destination function code, 0x002 cache control, 0x800 the user stack pointer, 0x801 the vector base and 0x802 the cache address. A read returns the last value written to that register.
- R2: Cache control (0x002) and cache address (0x802) keep only bits 7:0 of the written data. Reads of them return zero in bits 31:8.
- R3: The function code, user stack pointer and vector base registers keep all 32 written bits.
- R4: With `req_base_lvl` high, any number whose bits 10:0 exceed 1 is rejected, so 0x002 and 0x802 are refused. Numbers 0x000, 0x001, 0x800 and 0x801 are still accepted.
- R5: Any number outside the six listed in R1 is rejected, whatever the level.
- R6: A rejected write reports `rsp_trap_op` = 0x4E7B and a rejected read reports 0x4E7A. An accepted access reports 0x0000.
- R7: A rejected access changes no register and returns `rsp_rdata` = 0. Writes also return 0.
- R8: Each request accepted on a rising edge gives `rsp_valid` high for exactly one cycle, in the following cycle. `rsp_illegal` is high only together with `rsp_valid`.
- R9: Reset clears every register to zero and holds `rsp_valid` and `rsp_illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write control register, 0 = read |
| req_regnum | input | 12 | Control register number |
| req_wdata | input | 32 | Data for a write |
| req_base_lvl | input | 1 | Core is base level (restricted register set) |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Access was rejected |
| rsp_rdata | output | 32 | Read data for an accepted read, else zero |
| rsp_trap_op | output | 16 | Opcode to trap with when rejected, else zero |

## Verification
The assertions take two things for granted:

- `req_write`, `req_regnum` and `req_base_lvl` are defined, not X, in any cycle where `req_valid` is high.
- The requester never depends on a read and a write to the same register in the same cycle, because only one request can be issued per cycle.

The stimulus follows these rules by driving all request fields on the falling clock edge and holding them stable through the next rising edge. It deasserts `req_valid` between table vectors and issues back-to-back requests only in the directed ordering test. Reset is applied only while no request is pending.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
   localparam int NUM_CREG = 6;
   localparam int SEL_W    = $clog2(NUM_CREG);

   localparam logic [SEL_W-1:0] IDX_SFC  = SEL_W'(0);
   localparam logic [SEL_W-1:0] IDX_DFC  = SEL_W'(1);
   localparam logic [SEL_W-1:0] IDX_CCTL = SEL_W'(2);
   localparam logic [SEL_W-1:0] IDX_USP  = SEL_W'(3);
   localparam logic [SEL_W-1:0] IDX_VBAS = SEL_W'(4);
   localparam logic [SEL_W-1:0] IDX_CADR = SEL_W'(5);

   localparam logic [15:0] TRAP_OP_WR = 16'h4E7B;
   localparam logic [15:0] TRAP_OP_RD = 16'h4E7A;

   function automatic logic idx_is_narrow(input int idx);
      return (idx == int'(IDX_CCTL)) || (idx == int'(IDX_CADR));
   endfunction
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
   import ctlreg_pkg::*;
#(
   parameter int REGNUM_W = 12,
   parameter logic [REGNUM_W-1:0] NUM_SFC  = 'h000,
   parameter logic [REGNUM_W-1:0] NUM_DFC  = 'h001,
   parameter logic [REGNUM_W-1:0] NUM_CCTL = 'h002,
   parameter logic [REGNUM_W-1:0] NUM_USP  = 'h800,
   parameter logic [REGNUM_W-1:0] NUM_VBAS = 'h801,
   parameter logic [REGNUM_W-1:0] NUM_CADR = 'h802,
   parameter int BASE_MAX_LOW = 1
) (
   input  logic [REGNUM_W-1:0] regnum,
   input  logic                base_lvl,
   output logic [SEL_W-1:0]    sel,
   output logic                legal
);
   localparam int LOW_W = REGNUM_W - 1;

   generate
      if (REGNUM_W < 2) begin : g_bad_w
         $error("ctlreg_decode: REGNUM_W must be at least 2");
      end
   endgenerate

   logic known;
   logic base_block;

   always_comb begin
      known = 1'b1;
      sel   = IDX_SFC;
      case (regnum)
         NUM_SFC:  sel = IDX_SFC;
         NUM_DFC:  sel = IDX_DFC;
         NUM_CCTL: sel = IDX_CCTL;
         NUM_USP:  sel = IDX_USP;
         NUM_VBAS: sel = IDX_VBAS;
         NUM_CADR: sel = IDX_CADR;
         default:  known = 1'b0;
      endcase
      base_block = base_lvl && (regnum[LOW_W-1:0] > LOW_W'(BASE_MAX_LOW));
      legal      = known && !base_block;
   end
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
   import ctlreg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (NARROW_W < 1 || NARROW_W > DATA_W) begin : g_bad_narrow
         $error("ctlreg_file: NARROW_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] rd_bus [NUM_CREG];

   generate
      for (genvar gi = 0; gi < NUM_CREG; gi++) begin : g_reg
         localparam int KEEP_W = idx_is_narrow(gi) ? NARROW_W : DATA_W;
         logic [KEEP_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_sel == SEL_W'(gi))
               q <= wr_data[KEEP_W-1:0];
         end
         if (KEEP_W < DATA_W) begin : g_zx
            assign rd_bus[gi] = {{(DATA_W-KEEP_W){1'b0}}, q};
         end else begin : g_full
            assign rd_bus[gi] = q;
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CREG; i++)
         if (rd_sel == SEL_W'(i)) rd_data = rd_bus[i];
   end

   logic [NUM_CREG*DATA_W-1:0] all_regs;
   always_comb
      for (int i = 0; i < NUM_CREG; i++)
         all_regs[i*DATA_W +: DATA_W] = rd_bus[i];

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(all_regs)); // R7
endmodule

// File: rtl/ctlreg_move_unit.sv
module ctlreg_move_unit
   import ctlreg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 8,
   parameter int REGNUM_W = 12,
   parameter int OP_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [REGNUM_W-1:0] req_regnum,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic                req_base_lvl,
   output logic                rsp_valid,
   output logic                rsp_illegal,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic [OP_W-1:0]     rsp_trap_op
);
   generate
      if (OP_W < 16) begin : g_bad_op
         $error("ctlreg_move_unit: OP_W must hold a 16-bit opcode");
      end
   endgenerate

   logic [SEL_W-1:0]  sel;
   logic              legal;
   logic [DATA_W-1:0] rd_data;
   logic              wr_en;
   logic              rsp_narrow;

   ctlreg_decode #(.REGNUM_W(REGNUM_W)) u_dec (
      .regnum  (req_regnum),
      .base_lvl(req_base_lvl),
      .sel     (sel),
      .legal   (legal)
   );

   assign wr_en = req_valid && req_write && legal;

   ctlreg_file #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_file (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (sel),
      .wr_data(req_wdata),
      .rd_sel (sel),
      .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_illegal <= 1'b0;
         rsp_rdata   <= '0;
         rsp_trap_op <= '0;
         rsp_narrow  <= 1'b0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_illegal <= req_valid && !legal;
         rsp_rdata   <= (req_valid && !req_write && legal) ? rd_data : '0;
         rsp_narrow  <= idx_is_narrow(int'(sel)) && legal;
         if (req_valid && !legal)
            rsp_trap_op <= OP_W'(req_write ? TRAP_OP_WR : TRAP_OP_RD);
         else
            rsp_trap_op <= '0;
      end
   end

   AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R8
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R8
   AST_ILLEGAL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> rsp_valid); // R8
   AST_TRAP_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> rsp_trap_op == OP_W'($past(req_write) ? 16'h4E7B : 16'h4E7A)); // R6
   AST_BASE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_base_lvl && req_regnum[REGNUM_W-2:0] > 1) |=> rsp_illegal); // R4
   AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_narrow) |-> rsp_rdata[DATA_W-1:NARROW_W] == '0); // R2
   AST_REJECT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> rsp_rdata == '0); // R7
endmodule

// File: tb/tb_ctlreg_move_unit.sv
module tb_ctlreg_move_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_regnum = '0;
   logic [31:0] req_wdata = '0;
   logic        req_base_lvl = 1'b0;
   logic        rsp_valid;
   logic        rsp_illegal;
   logic [31:0] rsp_rdata;
   logic [15:0] rsp_trap_op;

   always #2.5 clk = ~clk;

   ctlreg_move_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_regnum(req_regnum), .req_wdata(req_wdata), .req_base_lvl(req_base_lvl),
      .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata),
      .rsp_trap_op(rsp_trap_op)
   );

   // {write, base, regnum[11:0], wdata[31:0], exp_illegal, exp_rdata[31:0]}
   localparam int NV = 27;
   localparam logic [78:0] VEC [NV] = '{
      {1'b0,1'b0,12'h000,32'h0,       1'b0,32'h0},        // R9 cleared
      {1'b0,1'b0,12'h802,32'h0,       1'b0,32'h0},        // R9 cleared
      {1'b1,1'b0,12'h000,32'hDEADBEEF,1'b0,32'h0},        // R1
      {1'b1,1'b0,12'h001,32'h12345678,1'b0,32'h0},        // R1
      {1'b1,1'b0,12'h002,32'hA5A5A5C3,1'b0,32'h0},        // R2
      {1'b1,1'b0,12'h800,32'hCAFEF00D,1'b0,32'h0},        // R1
      {1'b1,1'b0,12'h801,32'h00010400,1'b0,32'h0},        // R1
      {1'b1,1'b0,12'h802,32'hFFFFFF7E,1'b0,32'h0},        // R2
      {1'b0,1'b0,12'h000,32'h0,       1'b0,32'hDEADBEEF}, // R3
      {1'b0,1'b0,12'h001,32'h0,       1'b0,32'h12345678}, // R3
      {1'b0,1'b0,12'h002,32'h0,       1'b0,32'h000000C3}, // R2
      {1'b0,1'b0,12'h800,32'h0,       1'b0,32'hCAFEF00D}, // R3
      {1'b0,1'b0,12'h801,32'h0,       1'b0,32'h00010400}, // R3
      {1'b0,1'b0,12'h802,32'h0,       1'b0,32'h0000007E}, // R2
      {1'b1,1'b0,12'h003,32'h11111111,1'b1,32'h0},        // R5
      {1'b0,1'b0,12'h803,32'h0,       1'b1,32'h0},        // R5
      {1'b1,1'b1,12'h002,32'h22222222,1'b1,32'h0},        // R4
      {1'b0,1'b1,12'h802,32'h0,       1'b1,32'h0},        // R4
      {1'b0,1'b1,12'h800,32'h0,       1'b0,32'hCAFEF00D}, // R4
      {1'b1,1'b1,12'h801,32'h0BADCAFE,1'b0,32'h0},        // R4
      {1'b0,1'b0,12'h801,32'h0,       1'b0,32'h0BADCAFE}, // R1
      {1'b0,1'b0,12'h002,32'h0,       1'b0,32'h000000C3}, // R7
      {1'b1,1'b1,12'h001,32'h55AA55AA,1'b0,32'h0},        // R4
      {1'b0,1'b1,12'h001,32'h0,       1'b0,32'h55AA55AA}, // R4
      {1'b1,1'b0,12'hFFF,32'h99999999,1'b1,32'h0},        // R5
      {1'b0,1'b1,12'h7FF,32'h0,       1'b1,32'h0},        // R5
      {1'b0,1'b0,12'h000,32'h0,       1'b0,32'hDEADBEEF}  // R7
   };

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic check(input string req, input logic [49:0] act, input logic [49:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got valid/illegal/op/data %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic w, input logic b, input logic [11:0] rn, input logic [31:0] wd);
      req_valid = 1'b1; req_write = w; req_base_lvl = b; req_regnum = rn; req_wdata = wd;
   endtask

   function automatic logic [49:0] expect_rsp(input logic w, input logic ill, input logic [31:0] rd);
      logic [15:0] op;
      op = ill ? (w ? 16'h4E7B : 16'h4E7A) : 16'h0000;
      return {1'b1, ill, op, rd};
   endfunction

   function automatic string tag_of(input int i);
      if (i < 2) return "R9";
      if (i == 4 || i == 7 || i == 10 || i == 13) return "R2";
      if (i >= 8 && i <= 12) return "R3";
      if (i == 14 || i == 15 || i == 24 || i == 25) return "R5/R6";
      if (i >= 16 && i <= 19 || i == 22 || i == 23) return "R4/R6";
      if (i == 21 || i == 26) return "R7";
      return "R1";
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset outputs", {rsp_valid, rsp_illegal, rsp_trap_op, rsp_rdata}, 50'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle no response", {rsp_valid, rsp_illegal, rsp_trap_op, rsp_rdata}, 50'h0);

      for (int i = 0; i < NV; i++) begin
         logic [78:0] v;
         v = VEC[i];
         drive(v[78], v[77], v[76:65], v[64:33]);
         @(negedge clk);
         req_valid = 1'b0;
         check(tag_of(i), {rsp_valid, rsp_illegal, rsp_trap_op, rsp_rdata},
               expect_rsp(v[78], v[32], v[31:0]));
         @(negedge clk);
         check("R8 single-cycle response", {rsp_valid, rsp_illegal, 48'h0}, 50'h0);
      end

      // R8 back-to-back write then read of the same register
      drive(1'b1, 1'b0, 12'h800, 32'h13572468);
      @(negedge clk);
      check("R8 b2b write", {rsp_valid, rsp_illegal, rsp_trap_op, rsp_rdata}, expect_rsp(1'b1, 1'b0, 32'h0));
      drive(1'b0, 1'b0, 12'h800, 32'h0);
      @(negedge clk);
      check("R8 b2b read", {rsp_valid, rsp_illegal, rsp_trap_op, rsp_rdata}, expect_rsp(1'b0, 1'b0, 32'h13572468));
      drive(1'b1, 1'b0, 12'h004, 32'h0);
      @(negedge clk);
      check("R8 R6 reject pulse", {rsp_valid, rsp_illegal, rsp_trap_op, rsp_rdata}, expect_rsp(1'b1, 1'b1, 32'h0));
      drive(1'b0, 1'b0, 12'h001, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      check("R8 illegal drops after pulse", {rsp_valid, rsp_illegal, rsp_trap_op, rsp_rdata}, expect_rsp(1'b0, 1'b0, 32'h55AA55AA));
      @(negedge clk);

      // R9 reset mid-run clears stored values
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 12'h800, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 usp cleared", {rsp_valid, rsp_illegal, rsp_trap_op, rsp_rdata}, expect_rsp(1'b0, 1'b0, 32'h0));
      drive(1'b0, 1'b0, 12'h002, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 cache ctl cleared", {rsp_valid, rsp_illegal, rsp_trap_op, rsp_rdata}, expect_rsp(1'b0, 1'b0, 32'h0));
      @(negedge clk);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule